// File: doc/BRIEF.md
# Load-Store Byte Lane Aligner

This block sits between a processor's load/store stage and a data memory that is one 32-bit word wide. The processor presents a byte address, an access size, a direction and (for stores) the register value. One clock later the block drives the memory with a word address, the store data placed on the proper byte lanes and a per-lane write-enable mask. For loads, the memory returns the whole word in that cycle. The block then picks out the addressed byte, halfword or word and widens it to 32 bits with either sign or zero extension.

Lane order follows a mode input. When it is low, byte offset 0 is the most significant byte of the word. When it is high, byte offset 0 is the least significant byte. An access whose address does not suit its size raises a misaligned flag, and a store with that flag writes nothing. The flag is the only fault handling the block does.

Top module: `lsa_lane_align`

## Requirements
- R1: While reset is held and in the first cycle after it, mem_en, mem_wen and misaligned are all zero.
- R2: A request sampled with req_valid high gives, in the following cycle, mem_en = 1 and mem_word_addr = req_addr[ADDR_W-1:2]. A cycle after a clock edge with req_valid low gives mem_en = 0, mem_wen = 0 and misaligned = 0.
- R3: req_size encodes 00 = byte, 01 = halfword, 10 = word, 11 = word. For a store, mem_wdata repeats the low byte of req_wdata into all four lanes for a byte access, repeats the low halfword into both halves for a halfword access, and passes req_wdata through unchanged for a word access.
- R4: Lane k is mem_wdata[8k+7:8k] and is enabled by mem_wen[k]. With req_little = 0, a byte store at offset o sets only mem_wen[3-o]. A halfword store sets 4'b1100 at offset 0 and 4'b0011 at offset 2. A word store sets 4'b1111.
- R5: With req_little = 1, a byte store at offset o sets only mem_wen[o]. A halfword store sets 4'b0011 at offset 0 and 4'b1100 at offset 2. A word store sets 4'b1111.
- R6: The misaligned flag is set for a halfword access with req_addr[0] = 1 and for a word access with req_addr[1:0] != 0, for loads and stores alike. A byte access never sets it. When it is set, mem_wen is 0.
- R7: A byte load returns the byte at the addressed offset under the lane order of R4/R5. It is sign-extended when req_unsigned = 0 and zero-extended when req_unsigned = 1.
- R8: A halfword load returns the two bytes at offsets o and o+1. With req_little = 0 the byte at offset o is the upper one, and with req_little = 1 the byte at offset o+1 is the upper one. The result is extended as in R7.
- R9: A word load returns mem_rdata unchanged, whatever the lane order.
- R10: load_data follows mem_rdata combinationally in the cycle after the request, with no further clock edge. A load never asserts any bit of mem_wen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code |
| req_unsigned | input | 1 | Zero-extend load result |
| req_little | input | 1 | Lane order select, 1 = little-endian |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store source value |
| mem_rdata | input | 32 | Word returned by memory |
| mem_en | output | 1 | Memory access in progress |
| mem_word_addr | output | ADDR_W-2 | Word address to memory |
| mem_wen | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Lane-placed store data |
| misaligned | output | 1 | Address does not suit size |
| load_data | output | 32 | Extended load result |

## Verification
The bench sweeps every combination of lane order, size code, low address offset, direction and extension mode. It uses a changing upper address and a changing store value, so each store shows the lane replication and exactly which enables go high. Each load is then fed several memory words. Their bytes mix set and clear top bits, so sign extension is told apart from zero extension, and an upper lane is told apart from a lower one. Feeding the new words without a clock edge shows that the load path is combinational. Idle cycles between accesses show the enables and the flag returning to zero.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WALT = 2'b11
    } size_e;

    // Address offset does not suit access width
    function automatic logic off_bad(size_e sz, logic [OFF_W-1:0] off);
        case (sz)
            SZ_BYTE: off_bad = 1'b0;
            SZ_HALF: off_bad = off[0];
            default: off_bad = |off;
        endcase
    endfunction

    // Physical lane holding a given byte offset
    function automatic logic [OFF_W-1:0] byte_lane(logic le, logic [OFF_W-1:0] off);
        byte_lane = le ? off : ~off;
    endfunction

    // Halfword lives in the upper half of the word
    function automatic logic half_hi(logic le, logic [OFF_W-1:0] off);
        half_hi = le ? off[1] : ~off[1];
    endfunction

endpackage

// File: rtl/lsa_store_lanes.sv
module lsa_store_lanes
    import lsa_pkg::*;
(
    input  size_e                  size,
    input  logic [OFF_W-1:0]       off,
    input  logic                   le,
    input  logic                   is_store,
    input  logic [WORD_W-1:0]      src,
    output logic [WORD_W-1:0]      lanes,
    output logic [LANES-1:0]       wen,
    output logic                   bad
);

    logic [OFF_W-1:0] blane;
    logic             hsel;

    always_comb begin
        bad   = off_bad(size, off);
        blane = byte_lane(le, off);
        hsel  = half_hi(le, off);
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int HK = k % 2;
        localparam logic UPPER = (k >= LANES / 2);
        always_comb begin
            case (size)
                SZ_BYTE: lanes[8*k +: 8] = src[7:0];
                SZ_HALF: lanes[8*k +: 8] = src[8*HK +: 8];
                default: lanes[8*k +: 8] = src[8*k +: 8];
            endcase
            case (size)
                SZ_BYTE: wen[k] = (blane == OFF_W'(k));
                SZ_HALF: wen[k] = (hsel == UPPER);
                default: wen[k] = 1'b1;
            endcase
            wen[k] = wen[k] & is_store & ~bad;
        end
    end

endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
    import lsa_pkg::*;
(
    input  logic [WORD_W-1:0]  word,
    input  size_e              size,
    input  logic [OFF_W-1:0]   off,
    input  logic               le,
    input  logic               zext,
    output logic [WORD_W-1:0]  result
);

    logic [7:0]       byte_arr [LANES];
    logic [7:0]       b_sel;
    logic [15:0]      h_sel;
    logic [OFF_W-1:0] blane;

    for (genvar k = 0; k < LANES; k++) begin : g_split
        assign byte_arr[k] = word[8*k +: 8];
    end

    always_comb begin
        blane = byte_lane(le, off);
        b_sel = byte_arr[blane];
        h_sel = half_hi(le, off) ? word[31:16] : word[15:0];
        case (size)
            SZ_BYTE: result = {{24{b_sel[7]  & ~zext}}, b_sel};
            SZ_HALF: result = {{16{h_sel[15] & ~zext}}, h_sel};
            default: result = word;
        endcase
    end

endmodule

// File: rtl/lsa_lane_align.sv
module lsa_lane_align
    import lsa_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [1:0]           req_size,
    input  logic                 req_unsigned,
    input  logic                 req_little,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [31:0]          req_wdata,
    input  logic [31:0]          mem_rdata,
    output logic                 mem_en,
    output logic [ADDR_W-3:0]    mem_word_addr,
    output logic [3:0]           mem_wen,
    output logic [31:0]          mem_wdata,
    output logic                 misaligned,
    output logic [31:0]          load_data
);

    localparam int WA_W = ADDR_W - OFF_W;

    typedef struct packed {
        logic              en;
        logic              we;
        logic              bad;
        logic [LANES-1:0]  wen;
        logic [WORD_W-1:0] wdata;
        logic [WA_W-1:0]   waddr;
        size_e             size;
        logic [OFF_W-1:0]  off;
        logic              le;
        logic              zext;
    } ctx_t;

    ctx_t st_d, st_q;

    size_e             sz_in;
    logic [WORD_W-1:0] lanes_c;
    logic [LANES-1:0]  wen_c;
    logic              bad_c;

    assign sz_in = size_e'(req_size);

    lsa_store_lanes u_store (
        .size     (sz_in),
        .off      (req_addr[OFF_W-1:0]),
        .le       (req_little),
        .is_store (req_write),
        .src      (req_wdata),
        .lanes    (lanes_c),
        .wen      (wen_c),
        .bad      (bad_c)
    );

    always_comb begin
        st_d     = st_q;
        st_d.en  = req_valid;
        st_d.wen = '0;
        st_d.bad = 1'b0;
        st_d.we  = 1'b0;
        if (req_valid) begin
            st_d.we    = req_write;
            st_d.bad   = bad_c;
            st_d.wen   = wen_c;
            st_d.wdata = lanes_c;
            st_d.waddr = req_addr[ADDR_W-1:OFF_W];
            st_d.size  = sz_in;
            st_d.off   = req_addr[OFF_W-1:0];
            st_d.le    = req_little;
            st_d.zext  = req_unsigned;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    lsa_load_extract u_load (
        .word   (mem_rdata),
        .size   (st_q.size),
        .off    (st_q.off),
        .le     (st_q.le),
        .zext   (st_q.zext),
        .result (load_data)
    );

    assign mem_en        = st_q.en;
    assign mem_word_addr = st_q.waddr;
    assign mem_wen       = st_q.wen;
    assign mem_wdata     = st_q.wdata;
    assign misaligned    = st_q.bad;

    // R2: idle cycle drives nothing
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_en |-> (mem_wen == '0 && !misaligned));

    // R4/R5: enable count is 0, 1, 2 or 4
    p_wen_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mem_wen) != 3);

    // R4: byte store touches one lane
    p_byte_one_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && st_q.we && st_q.size == SZ_BYTE) |-> $countones(mem_wen) == 1);

    // R6: flagged access never writes
    p_bad_no_wen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned |-> mem_wen == '0);

    // R10: loads never write
    p_load_no_wen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !st_q.we) |-> mem_wen == '0);

    // R7: unsigned byte load has clear upper bits
    p_ubyte_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !st_q.we && st_q.zext && st_q.size == SZ_BYTE) |-> load_data[31:8] == '0);

endmodule

// File: tb/lsa_lane_align_bench.sv
`timescale 1ns/1ps
module lsa_lane_align_bench;

    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [1:0]        req_size = '0;
    logic              req_unsigned = 1'b0;
    logic              req_little = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic [31:0]       mem_rdata = '0;
    logic              mem_en;
    logic [ADDR_W-3:0] mem_word_addr;
    logic [3:0]        mem_wen;
    logic [31:0]       mem_wdata;
    logic              misaligned;
    logic [31:0]       load_data;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    lsa_lane_align #(.ADDR_W(ADDR_W)) u_lsa_lane_align (
        .clk, .rst_n, .req_valid, .req_write, .req_size, .req_unsigned,
        .req_little, .req_addr, .req_wdata, .mem_rdata, .mem_en,
        .mem_word_addr, .mem_wen, .mem_wdata, .misaligned, .load_data
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Byte held at byte offset o of a memory word under the chosen lane order
    function automatic logic [7:0] byte_at(logic [31:0] w, int o, bit le);
        int lane = le ? o : 3 - o;
        return w[8*lane +: 8];
    endfunction

    function automatic logic [3:0] exp_wen(bit le, int sz, int off);
        logic [3:0] m = '0;
        if (sz == 0) m[le ? off : 3 - off] = 1'b1;
        else if (sz == 1) begin
            for (int i = 0; i < 2; i++) m[le ? off + i : 3 - off - i] = 1'b1;
        end else m = 4'hF;
        return m;
    endfunction

    function automatic logic [31:0] exp_load(logic [31:0] w, bit le, int sz, int off, bit uns);
        logic [7:0]  b;
        logic [15:0] h;
        if (sz == 0) begin
            b = byte_at(w, off, le);
            return uns ? {24'h0, b} : {{24{b[7]}}, b};
        end else if (sz == 1) begin
            h = le ? {byte_at(w, off + 1, le), byte_at(w, off, le)}
                   : {byte_at(w, off, le), byte_at(w, off + 1, le)};
            return uns ? {16'h0, h} : {{16{h[15]}}, h};
        end
        return w;
    endfunction

    logic [31:0] pats [4] = '{32'h80FF7F01, 32'h7E81C3A5, 32'h12345678, 32'h89ABCDEF};

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n = 0;
        repeat (3) @(negedge clk);
        chk(mem_en == 0 && mem_wen == 0 && misaligned == 0, "R1 in reset",
            {mem_en, mem_wen, misaligned}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_en == 0 && mem_wen == 0 && misaligned == 0, "R1 after reset",
            {mem_en, mem_wen, misaligned}, 0);

        for (int le = 0; le < 2; le++)
        for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 4; off++)
        for (int wr = 0; wr < 2; wr++)
        for (int un = 0; un < 2; un++) begin
            logic [31:0] a, d;
            bit bad;
            int esz;
            n++;
            esz = (sz == 3) ? 2 : sz;
            a = {n[15:0] * 16'h9E37, 14'(n * 7), 2'(off)};
            d = 32'hA1B2C3D4 ^ (n * 32'h01010101) ^ {n[7:0], 24'h0};
            bad = (esz == 1 && off[0]) || (esz == 2 && off != 0);
            req_valid = 1'b1; req_write = wr[0]; req_size = sz[1:0];
            req_unsigned = un[0]; req_little = le[0]; req_addr = a; req_wdata = d;
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            chk(mem_en == 1'b1, "R2 mem_en", mem_en, 1);
            chk(mem_word_addr == a[31:2], "R2 word addr", mem_word_addr, a[31:2]);
            chk(misaligned == bad, "R6 flag", misaligned, bad);
            if (wr) begin
                logic [31:0] ew;
                logic [3:0]  em;
                ew = (esz == 0) ? {4{d[7:0]}} : (esz == 1) ? {2{d[15:0]}} : d;
                em = bad ? 4'h0 : exp_wen(le[0], esz, off);
                chk(mem_wdata == ew, "R3 store lanes", mem_wdata, ew);
                chk(mem_wen == em, le ? "R5 le enables" : "R4 be enables", mem_wen, em);
            end else begin
                chk(mem_wen == 4'h0, "R10 load no write", mem_wen, 0);
                if (!bad) begin
                    for (int p = 0; p < 4; p++) begin
                        logic [31:0] el;
                        mem_rdata = pats[p];
                        #0.4;
                        el = exp_load(pats[p], le[0], esz, off, un[0]);
                        chk(load_data == el,
                            esz == 0 ? "R7 byte load R10" : esz == 1 ? "R8 half load R10" : "R9 word load R10",
                            load_data, el);
                    end
                end
            end
            // idle gap
            @(posedge clk);
            @(negedge clk);
            chk(mem_en == 0 && mem_wen == 0 && misaligned == 0, "R2 idle",
                {mem_en, mem_wen, misaligned}, 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule